// File: doc/BRIEF.md
# Random Word Generator Register Block

This block is a memory-mapped random-number source on a simple 32-bit register bus. It has three registers: control, status and data. Software programs a power-of-two divider for the generator clock and starts generation. A conditional-reset handshake must finish before any words are produced. After that, the block fills a four-word output buffer. When the buffer is full, the block raises a ready flag, and software may then read four fresh words in a row.

A deterministic 32-bit linear-feedback shift register stands in for the entropy source, so every word is predictable in test. A test input injects seed faults. The block reports a seed fault as a live state bit and as a sticky flag. Software recovers by clearing the sticky flag and then reading the data register twelve times.

A clock-error flag warns when the divided generator clock is faster than the allowed maximum rate. Software can switch this detection off.

Top module: `rng_regif`

## Requirements
- R1: After reset, the control, status and data registers all read as zero.
- R2: Control register at offset 0x0: bit 2 is enable, bit 5 set switches clock-error detection off, bits 19:16 hold the divider exponent, bit 30 is the conditional-reset bit. Status register at offset 0x4: bit 0 is ready, bit 2 is the live seed-fault state, bit 5 is the sticky clock-error flag, bit 6 is the sticky seed-fault flag. All other bits of both registers read as zero.
- R3: Writing 1 to control bit 30 holds the block in reset, flushes the buffer and reloads the seed 0x1F2E3D4C. A following write with bit 30 at 0 starts a 16-cycle sequence. Bit 30 keeps reading 1 until 16 clock edges after that write, then reads 0.
- R4: Each word is the next state of the generator x' = {0, x[31:1]} XOR (x[0] ? 0x80200003 : 0), counted from the reloaded seed. While ready is high, four reads of the data register at offset 0x8 return four consecutive words in generation order.
- R5: Ready drops with the fourth read. It is next seen exactly 4·2^div cycles after that read.
- R6: The generator makes one word per 2^div kernel cycles. Ready is first seen 4·2^div − 1 cycles after bit 30 is first seen clear.
- R7: With enable set and detection on, the sticky clock-error flag sets when 100 MHz / 2^div exceeds 48 MHz, that is when div < 2. With bit 5 set, the flag does not set.
- R8: A status write clears a sticky flag where the written bit is 0 and leaves it where the written bit is 1. Writing 0 clears both flags.
- R9: While the seed fault input is high, the live state and the sticky flag both read 1. Ready reads 0 and data reads return zero.
- R10: After the fault input falls, clearing the sticky flag and then making 12 data reads clears the live state. After 11 reads it is still set. Clearing the flag while the fault persists has no lasting effect, because the flag sets again.
- R11: Writes to the data register do not change the buffered words. Writing 0 to the control register stops generation, and ready stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| seed_fault | input | 1 | Test input that injects a seed fault |

## Verification
The bench uses the default parameters: 100 MHz kernel clock, 48 MHz maximum generator rate, four-word burst, 16-cycle reset sequence, and 12 recovery reads. With these values the smallest safe divider exponent is 2. Exponents 0 and 1 therefore trip the clock-error flag, and exponent 2 and above do not. Divider exponents 0 to 3 keep every refill within a few dozen cycles. This allows the exact refill cycle counts to be checked for each exponent. The fixed seed makes each word checkable against a model of the generator in the bench.

// File: rtl/rng_regif.sv
module rng_regif #(
  parameter int unsigned KERNEL_HZ     = 100_000_000,
  parameter int unsigned MAX_GEN_HZ    = 48_000_000,
  parameter int unsigned BURST         = 4,
  parameter int unsigned RST_CYCLES    = 16,
  parameter int unsigned RECOVER_READS = 12,
  parameter logic [31:0] SEED          = 32'h1F2E_3D4C,
  parameter logic [31:0] TAPS          = 32'h8020_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        seed_fault
);
  localparam int IW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam int CW = $clog2(BURST + 1);
  localparam int RW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam int VW = $clog2(RECOVER_READS + 1);

  function automatic logic [3:0] min_exp_f();
    for (int e = 0; e < 16; e++)
      if ((KERNEL_HZ >> e) <= MAX_GEN_HZ) return 4'(e);
    return 4'd15;
  endfunction
  localparam logic [3:0] MIN_EXP = min_exp_f();

  logic          en_q, ced_off_q, crst_q, crun_q;
  logic [3:0]    div_q;
  logic [RW-1:0] ccnt_q;
  logic [15:0]   pcnt_q;
  logic [31:0]   lfsr_q;
  logic [31:0]   buf_q [BURST];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] rptr_q;
  logic          rdy_q, secs_q, seis_q, ceis_q;
  logic [VW-1:0] rcnt_q;

  wire wr_cr = bus_sel && bus_we && (bus_addr == 4'h0);
  wire wr_sr = bus_sel && bus_we && (bus_addr == 4'h4);
  wire wr_dr = bus_sel && bus_we && (bus_addr == 4'h8);
  wire rd_dr = bus_sel && !bus_we && (bus_addr == 4'h8);

  wire        gen_on   = en_q && !crst_q && !secs_q;
  wire [15:0] pmask    = (16'd1 << div_q) - 16'd1;
  wire        tick     = gen_on && !rdy_q && (pcnt_q == pmask);
  wire        pop      = rd_dr && rdy_q && gen_on;
  wire        too_fast = (div_q < MIN_EXP);
  wire        rdy_vis  = rdy_q && !secs_q;
  wire [31:0] lfsr_nx  = {1'b0, lfsr_q[31:1]} ^ (lfsr_q[0] ? TAPS : 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ced_off_q <= 1'b0; div_q <= '0;
      crst_q <= 1'b0; crun_q <= 1'b0; ccnt_q <= '0;
    end else begin
      if (crun_q) begin
        if (ccnt_q == RW'(RST_CYCLES - 1)) begin
          crst_q <= 1'b0;
          crun_q <= 1'b0;
        end else begin
          ccnt_q <= ccnt_q + 1'b1;
        end
      end
      if (wr_cr) begin
        en_q      <= bus_wdata[2];
        ced_off_q <= bus_wdata[5];
        div_q     <= bus_wdata[19:16];
        if (bus_wdata[30]) begin
          crst_q <= 1'b1;
          crun_q <= 1'b0;
        end else if (crst_q && !crun_q) begin
          crun_q <= 1'b1;
          ccnt_q <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lfsr_q <= SEED;
    else if (crst_q) lfsr_q <= SEED;
    else if (tick)   lfsr_q <= lfsr_nx;
  end

  always_ff @(posedge clk) begin
    if (tick) buf_q[cnt_q[IW-1:0]] <= lfsr_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; rptr_q <= '0; rdy_q <= 1'b0; pcnt_q <= '0;
    end else if (!gen_on) begin
      cnt_q <= '0; rptr_q <= '0; rdy_q <= 1'b0; pcnt_q <= '0;
    end else begin
      pcnt_q <= (rdy_q || tick) ? 16'd0 : pcnt_q + 16'd1;
      if (tick) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(BURST - 1)) rdy_q <= 1'b1;
      end
      if (pop) begin
        cnt_q  <= cnt_q - 1'b1;
        rptr_q <= rptr_q + 1'b1;
        if (cnt_q == CW'(1)) rdy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q <= 1'b0; seis_q <= 1'b0; ceis_q <= 1'b0; rcnt_q <= '0;
    end else begin
      if (seed_fault) seis_q <= 1'b1;
      else if (wr_sr) seis_q <= seis_q & bus_wdata[6];

      if (en_q && !ced_off_q && too_fast) ceis_q <= 1'b1;
      else if (wr_sr)                     ceis_q <= ceis_q & bus_wdata[5];

      if (!secs_q || seis_q) rcnt_q <= '0;
      else if (rd_dr)
        rcnt_q <= (rcnt_q == VW'(RECOVER_READS - 1)) ? '0 : rcnt_q + 1'b1;

      if (seed_fault) secs_q <= 1'b1;
      else if (secs_q && !seis_q && rd_dr && (rcnt_q == VW'(RECOVER_READS - 1)))
        secs_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        4'h0: bus_rdata = {1'b0, crst_q, 10'b0, div_q, 10'b0, ced_off_q, 2'b0, en_q, 2'b0};
        4'h4: bus_rdata = {25'b0, seis_q, ceis_q, 2'b0, secs_q, 1'b0, rdy_vis};
        4'h8: bus_rdata = rdy_vis ? buf_q[rptr_q] : 32'h0;
        default: bus_rdata = 32'h0;
      endcase
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BURST)) else $error("buffer count above burst size");

  assert_rdy_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> (cnt_q == CW'(BURST))) else $error("ready without full buffer");

  assert_crst_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (crun_q && ccnt_q == RW'(RST_CYCLES - 1) && !(wr_cr && bus_wdata[30])) |=> !crst_q)
    else $error("conditional reset did not finish");

  assert_seed_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crst_q |=> (lfsr_q == SEED)) else $error("seed not reloaded");

  assert_seed_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    secs_q |=> (cnt_q == '0 && !rdy_q)) else $error("buffer kept during seed fault");

  assert_dr_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dr && rdy_q && gen_on) |=> (cnt_q == $past(cnt_q) && rptr_q == $past(rptr_q)))
    else $error("data write disturbed buffer");
endmodule

// File: tb/rng_regif_tb.sv
module rng_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we, seed_fault;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0;
  int fails  = 0;
  logic [31:0] model;

  localparam logic [31:0] SEED_V = 32'h1F2E_3D4C;
  // {ced_off, expected clock-error flag, divider exponent}
  localparam logic [5:0] CFG [5] = '{6'b01_0000, 6'b01_0001, 6'b00_0010, 6'b10_0001, 6'b00_0011};

  always #5 clk = ~clk;

  rng_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seed_fault(seed_fault)
  );

  function automatic logic [31:0] step(input logic [31:0] x);
    return {1'b0, x[31:1]} ^ (x[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic poll(output int n);
    logic [31:0] s;
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      rd(4'h4, s);
      if (s[0]) break;
      n++;
    end
  endtask

  task automatic run_cfg(input int d, input bit c);
    int n;
    wr(4'h0, 32'h4000_0000 | (32'(d) << 16) | (32'(c) << 5));
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h0000_0004 | (32'(d) << 16) | (32'(c) << 5));
    model = SEED_V;
    poll(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n;
    rst_n = 1'b0; seed_fault = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'h0, v); chk("R1 control", v, 32'h0);
    rd(4'h4, v); chk("R1 status", v, 32'h0);
    rd(4'h8, v); chk("R1 data", v, 32'h0);

    for (int i = 0; i < 5; i++) begin
      int d; bit c; bit e; logic [31:0] cfgw;
      d = int'(CFG[i][3:0]); c = CFG[i][5]; e = CFG[i][4];
      cfgw = (32'(d) << 16) | (32'(c) << 5);
      wr(4'h0, 32'h4000_0000 | cfgw);
      wr(4'h4, 32'h0);
      wr(4'h0, 32'h4 | cfgw);
      model = SEED_V;
      repeat (15) @(negedge clk);
      rd(4'h0, v); chk("R3 busy at 15", v, 32'h4000_0004 | cfgw);
      rd(4'h0, v); chk("R3 clear at 16", v, 32'h4 | cfgw);
      poll(n); chk("R6 first fill cycles", 32'(n), 32'(4 * (1 << d) - 1));
      for (int k = 0; k < 4; k++) begin
        model = step(model); rd(4'h8, v); chk("R4 burst1 word", v, model);
      end
      poll(n); chk("R5 refill cycles", 32'(n), 32'(4 * (1 << d)));
      for (int k = 0; k < 4; k++) begin
        model = step(model); rd(4'h8, v); chk("R4 burst2 word", v, model);
      end
      rd(4'h4, v); chk("R7 clock error flag", 32'(v[5]), 32'(e));
      rd(4'h0, v); chk("R2 control readback", v, 32'h4 | cfgw);
    end

    run_cfg(2, 1'b0);
    wr(4'h8, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      model = step(model); rd(4'h8, v); chk("R11 data write ignored", v, model);
    end

    wr(4'h4, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R2 reserved control bits", v, 32'h400F_0024);
    rd(4'h4, v); chk("R2 reserved status bits", v, 32'h0);
    wr(4'h0, 32'h0002_0004);
    repeat (20) @(negedge clk);

    wr(4'h0, 32'h4000_0000);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h4);
    repeat (20) @(negedge clk);
    rd(4'h4, v); chk("R7 fast clock flags", 32'(v[5]), 32'h1);
    wr(4'h0, 32'h24);
    rd(4'h4, v); chk("R8 flag sticky", 32'(v[5]), 32'h1);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); chk("R8 write one keeps", 32'(v[5]), 32'h1);
    wr(4'h4, 32'h0);
    rd(4'h4, v); chk("R8 write zero clears", 32'(v[5]), 32'h0);

    wr(4'h0, 32'h0);
    repeat (100) @(negedge clk);
    rd(4'h4, v); chk("R11 stopped status", v, 32'h0);
    rd(4'h8, v); chk("R11 stopped data", v, 32'h0);

    run_cfg(2, 1'b0);
    seed_fault = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'h4, v); chk("R9 fault status", v, 32'h44);
    rd(4'h8, v); chk("R9 fault data zero", v, 32'h0);
    wr(4'h4, 32'h0);
    rd(4'h4, v); chk("R10 flag returns while fault", v, 32'h44);
    seed_fault = 1'b0;
    wr(4'h4, 32'h0);
    rd(4'h4, v); chk("R10 flag cleared", v, 32'h04);
    for (int k = 0; k < 11; k++) begin
      rd(4'h8, v); chk("R9 recovery read zero", v, 32'h0);
    end
    rd(4'h4, v); chk("R10 still faulted after 11", v, 32'h04);
    rd(4'h8, v);
    rd(4'h4, v); chk("R10 recovered after 12", v, 32'h00);
    poll(n);
    rd(4'h4, v); chk("R10 ready resumes", 32'(v[0]), 32'h1);

    summary();
  end
endmodule